// File: doc/BRIEF.md
# Eight-Bit ALU with Flag Register

This block is the arithmetic and logic stage of a small eight-bit processor core. It takes an accumulator byte and a second operand in the same cycle and returns the result combinationally. The second operand is either a register byte or an immediate byte, chosen by the low opcode bit. It also holds the four processor flags: zero, sign, carry and interrupt. At the end of every enabled cycle it updates only the flags that the current operation class is allowed to change.

The supported operations are add, add with carry, subtract, subtract with borrow, AND, OR, XOR, increment, decrement and clear-flags. For increment and decrement, the register file routes the chosen register onto the accumulator input. Alongside the result, the block exposes three things:
- the merged next flag vector;
- a per-flag write mask;
- a legality bit.

With these, the surrounding pipeline can see which flags an operation touches.

A side input lets the controller load the interrupt flag in the same enabled cycle. Flag vector bit order is Z=bit 0, S=bit 1, C=bit 2, I=bit 3.

Top module: `alu8_flags_unit`

## Requirements
- R1: Opcodes 0x40..0x43 add: 0x40/0x41 compute acc+operand, and 0x42/0x43 also add 1 when the stored C is 1. The result is the low 8 bits, and the next C is 1 exactly when the unsigned sum exceeds 0xFF.
- R2: Opcodes 0x44..0x47 subtract: 0x44/0x45 compute acc-operand, and 0x46/0x47 also subtract 1 when the stored C is 1. The result is the low 8 bits, and the next C is 1 exactly when the true difference is below zero.
- R3: For add/subtract, increment (0x50..0x56, result acc+1) and decrement (0x60..0x66, result acc-1), the next Z is 1 when the 8-bit result is zero, and the next S equals result bit 7.
- R4: Opcodes 0x70/0x71 AND, 0x72/0x73 OR and 0x74/0x75 XOR the accumulator with the operand. They update only Z (set on a zero result) and leave S and C unchanged.
- R5: Increment and decrement never change C.
- R6: Opcode 0x4F returns the accumulator unchanged, clears Z, S and C, and leaves I unchanged.
- R7: In the add, subtract and logic ranges, an odd opcode selects `imm` as the second operand and an even opcode selects `reg_b`.
- R8: Flags change only at a rising clock edge with `op_en` high. With `op_en` low they hold.
- R9: Any other opcode drives `op_legal` low, returns the accumulator unchanged and leaves Z, S and C unchanged. All listed opcodes drive `op_legal` high.
- R10: `flag_we` bits [2:0] are 3'b111 for add/subtract/clear-flags, 3'b011 for increment/decrement, 3'b001 for logic and 3'b000 for illegal opcodes. Bit 3 equals `int_wr`.
- R11: Asynchronous reset clears all four flags.
- R12: With `op_en` and `int_wr` high, I takes `int_val` at the clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_en | input | 1 | Operation enable; commits the flag update |
| opcode | input | 8 | Operation code |
| acc_in | input | 8 | Accumulator operand |
| reg_b | input | 8 | Register second operand |
| imm | input | 8 | Immediate second operand |
| int_wr | input | 1 | Load the interrupt flag this cycle |
| int_val | input | 1 | Value for the interrupt flag |
| result | output | 8 | Combinational result |
| op_legal | output | 1 | Opcode is one this block executes |
| flag_we | output | 4 | Per-flag write mask {I,C,S,Z} |
| flag_next | output | 4 | Flag vector after this operation |
| flags | output | 4 | Registered flags {I,C,S,Z} |

## Verification
The only internal state is the flag register, so a wrong flag value first shows on `flags` one cycle after the faulty operation. It then shows again on `result` in the next add-with-carry or subtract-with-borrow, which consume the stored carry. A mask error is visible at once on `flag_we`. It is also visible one edge later as a flag that moved or stayed when it should not have. The bench therefore compares the result and mask before each edge and the flags after it, for every operation. Carry-preserving classes are run directly after carry-setting ones.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  localparam int NFLAG = 4;
  localparam int FZ = 0;
  localparam int FS = 1;
  localparam int FC = 2;
  localparam int FI = 3;

  typedef enum logic [2:0] {
    OC_NONE  = 3'd0,
    OC_ADD   = 3'd1,
    OC_SUB   = 3'd2,
    OC_LOGIC = 3'd3,
    OC_INC   = 3'd4,
    OC_DEC   = 3'd5,
    OC_CLRF  = 3'd6
  } opclass_e;

  typedef struct packed {
    opclass_e   cls;
    logic       use_imm;
    logic       with_c;
    logic [1:0] lsel;   // 0 and, 1 or, 2 xor
  } alu_dec_t;
endpackage

// File: rtl/alu8_decode.sv
module alu8_decode
  import alu8_pkg::*;
(
  input  logic [7:0] opcode,
  output alu_dec_t   dec,
  output logic       legal
);
  always_comb begin
    dec = '{cls: OC_NONE, use_imm: 1'b0, with_c: 1'b0, lsel: 2'd0};
    unique case (opcode[7:4])
      4'h4: begin
        if (!opcode[3]) begin
          dec.cls     = opcode[2] ? OC_SUB : OC_ADD;
          dec.with_c  = opcode[1];
          dec.use_imm = opcode[0];
        end else if (opcode[3:0] == 4'hF) begin
          dec.cls = OC_CLRF;
        end
      end
      4'h5: if (opcode[3:0] <= 4'h6) dec.cls = OC_INC;
      4'h6: if (opcode[3:0] <= 4'h6) dec.cls = OC_DEC;
      4'h7: begin
        if (opcode[3:0] <= 4'h5) begin
          dec.cls     = OC_LOGIC;
          dec.lsel    = opcode[2:1];
          dec.use_imm = opcode[0];
        end
      end
      default: ;
    endcase
    legal = (dec.cls != OC_NONE);
  end
endmodule

// File: rtl/alu8_datapath.sv
module alu8_datapath
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input  alu_dec_t         dec,
  input  logic [W-1:0]     a,
  input  logic [W-1:0]     b,
  input  logic [W-1:0]     n,
  input  logic             cin,
  output logic [W-1:0]     res,
  output logic [NFLAG-1:0] raw,
  output logic [NFLAG-1:0] we
);
  logic [W-1:0] opnd;
  logic [W:0]   cext;
  logic [W:0]   sum;
  logic [W:0]   dif;
  logic         c_out;
  logic         zs_from_res;

  assign opnd = dec.use_imm ? n : b;
  assign cext = {{W{1'b0}}, dec.with_c & cin};
  assign sum  = {1'b0, a} + {1'b0, opnd} + cext;
  assign dif  = {1'b0, a} - {1'b0, opnd} - cext;

  always_comb begin
    res         = a;
    c_out       = 1'b0;
    we          = '0;
    zs_from_res = 1'b1;
    unique case (dec.cls)
      OC_ADD: begin
        res = sum[W-1:0];
        c_out = sum[W];
        we = 4'b0111;
      end
      OC_SUB: begin
        res = dif[W-1:0];
        c_out = dif[W];
        we = 4'b0111;
      end
      OC_INC: begin
        res = a + {{(W-1){1'b0}}, 1'b1};
        we = 4'b0011;
      end
      OC_DEC: begin
        res = a - {{(W-1){1'b0}}, 1'b1};
        we = 4'b0011;
      end
      OC_LOGIC: begin
        we = 4'b0001;
        unique case (dec.lsel)
          2'd0:    res = a & opnd;
          2'd1:    res = a | opnd;
          default: res = a ^ opnd;
        endcase
      end
      OC_CLRF: begin
        we = 4'b0111;
        zs_from_res = 1'b0;
      end
      default: ;
    endcase
    raw     = '0;
    raw[FZ] = zs_from_res & (res == '0);
    raw[FS] = zs_from_res & res[W-1];
    raw[FC] = c_out;
  end
endmodule

// File: rtl/alu8_flagreg.sv
module alu8_flagreg
  import alu8_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [NFLAG-1:0] alu_we,
  input  logic [NFLAG-1:0] alu_raw,
  input  logic             int_wr,
  input  logic             int_val,
  output logic [NFLAG-1:0] we,
  output logic [NFLAG-1:0] nxt,
  output logic [NFLAG-1:0] q
);
  logic [NFLAG-1:0] src;

  always_comb begin
    we      = alu_we;
    we[FI]  = int_wr;
    src     = alu_raw;
    src[FI] = int_val;
  end

  for (genvar i = 0; i < NFLAG; i++) begin : g_bit
    assign nxt[i] = we[i] ? src[i] : q[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else if (en) q <= nxt;
  end
endmodule

// File: rtl/alu8_flags_unit.sv
module alu8_flags_unit
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             op_en,
  input  logic [7:0]       opcode,
  input  logic [W-1:0]     acc_in,
  input  logic [W-1:0]     reg_b,
  input  logic [W-1:0]     imm,
  input  logic             int_wr,
  input  logic             int_val,
  output logic [W-1:0]     result,
  output logic             op_legal,
  output logic [NFLAG-1:0] flag_we,
  output logic [NFLAG-1:0] flag_next,
  output logic [NFLAG-1:0] flags
);
  alu_dec_t         dec;
  logic [NFLAG-1:0] dp_raw;
  logic [NFLAG-1:0] dp_we;

  alu8_decode u_dec (
    .opcode (opcode),
    .dec    (dec),
    .legal  (op_legal)
  );

  alu8_datapath #(.W(W)) u_dp (
    .dec (dec),
    .a   (acc_in),
    .b   (reg_b),
    .n   (imm),
    .cin (flags[FC]),
    .res (result),
    .raw (dp_raw),
    .we  (dp_we)
  );

  alu8_flagreg u_fr (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (op_en),
    .alu_we  (dp_we),
    .alu_raw (dp_raw),
    .int_wr  (int_wr),
    .int_val (int_val),
    .we      (flag_we),
    .nxt     (flag_next),
    .q       (flags)
  );
endmodule

// File: rtl/alu8_flags_chk.sv
module alu8_flags_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       op_en,
  input logic [7:0] opcode,
  input logic       int_wr,
  input logic       int_val,
  input logic       op_legal,
  input logic [3:0] flag_we,
  input logic [3:0] flags
);
  // R8
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !op_en |=> $stable(flags));

  // R9
  illegal_keeps_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_en && !op_legal && !int_wr) |=> $stable(flags));

  // R5
  incdec_keeps_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_en && (opcode[7:4] == 4'h5 || opcode[7:4] == 4'h6)) |=> (flags[2] == $past(flags[2])));

  // R4
  logic_keeps_sc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_en && opcode[7:4] == 4'h7) |=> $stable(flags[2:1]));

  // R6
  clrf_keeps_int_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_en && opcode == 8'h4F && !int_wr) |=> (flags[2:0] == 3'b000 && flags[3] == $past(flags[3])));

  // R12
  int_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_en && int_wr) |=> (flags[3] == $past(int_val)));

  // R10
  always_comb begin
    if (rst_n && !op_legal) begin
      illegal_mask_chk: assert (flag_we[2:0] == 3'b000);
    end
  end
endmodule

bind alu8_flags_unit alu8_flags_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .op_en    (op_en),
  .opcode   (opcode),
  .int_wr   (int_wr),
  .int_val  (int_val),
  .op_legal (op_legal),
  .flag_we  (flag_we),
  .flags    (flags)
);

// File: tb/tb_alu8_flags_unit.sv
module tb_alu8_flags_unit;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       op_en;
  logic [7:0] opcode, acc_in, reg_b, imm;
  logic       int_wr, int_val;
  logic [7:0] result;
  logic       op_legal;
  logic [3:0] flag_we, flag_next, flags;

  int checks = 0;
  int errors = 0;
  bit [3:0] mflags;   // model {I,C,S,Z}

  always #5 clk = ~clk;

  alu8_flags_unit dut (
    .clk(clk), .rst_n(rst_n), .op_en(op_en), .opcode(opcode), .acc_in(acc_in),
    .reg_b(reg_b), .imm(imm), .int_wr(int_wr), .int_val(int_val), .result(result),
    .op_legal(op_legal), .flag_we(flag_we), .flag_next(flag_next), .flags(flags)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic ref_eval(input [7:0] opc, input int a, input int b, input int n,
                          output int res, output bit [3:0] we, output bit [3:0] nf,
                          output bit legal);
    int op2, cin, t;
    bit dozs;
    op2 = opc[0] ? n : b;
    cin = mflags[2];
    res = a; we = 4'b0000; nf = 4'b0000; legal = 1'b1; dozs = 1'b1;
    if (opc >= 8'h40 && opc <= 8'h43) begin
      t = a + op2 + ((opc >= 8'h42) ? cin : 0);
      res = t % 256; nf[2] = (t > 255); we = 4'b0111;
    end else if (opc >= 8'h44 && opc <= 8'h47) begin
      t = a - op2 - ((opc >= 8'h46) ? cin : 0);
      res = (t + 512) % 256; nf[2] = (t < 0); we = 4'b0111;
    end else if (opc == 8'h4F) begin
      we = 4'b0111; dozs = 1'b0;
    end else if (opc >= 8'h50 && opc <= 8'h56) begin
      res = (a + 1) % 256; we = 4'b0011;
    end else if (opc >= 8'h60 && opc <= 8'h66) begin
      res = (a + 255) % 256; we = 4'b0011;
    end else if (opc >= 8'h70 && opc <= 8'h75) begin
      if (opc <= 8'h71) res = a & op2;
      else if (opc <= 8'h73) res = a | op2;
      else res = a ^ op2;
      we = 4'b0001;
    end else begin
      legal = 1'b0; dozs = 1'b0;
    end
    if (dozs) begin
      nf[0] = (res == 0);
      nf[1] = (res >= 128);
    end
  endtask

  task automatic do_op(input string tag, input bit en, input [7:0] opc, input [7:0] a,
                       input [7:0] b, input [7:0] n, input bit iw, input bit iv);
    int       eres;
    bit [3:0] ewe, enf;
    bit       elegal;
    @(negedge clk);
    op_en = en; opcode = opc; acc_in = a; reg_b = b; imm = n; int_wr = iw; int_val = iv;
    #1;
    ref_eval(opc, a, b, n, eres, ewe, enf, elegal);
    ewe[3] = iw; enf[3] = iv;
    check(tag, result, eres);
    check("R9", op_legal, elegal);
    check("R10", flag_we, ewe);
    @(posedge clk);
    #1;
    if (en) mflags = (enf & ewe) | (mflags & ~ewe);
    check(tag, flags, mflags);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; op_en = 1'b0; opcode = 8'h00; acc_in = 8'h00; reg_b = 8'h00;
    imm = 8'h00; int_wr = 1'b0; int_val = 1'b0;
    mflags = 4'b0000;
    repeat (3) @(posedge clk);
    #1;
    check("R11", flags, 0);
    @(negedge clk);
    rst_n = 1'b1;

    do_op("R3",  1, 8'h40, 8'h7F, 8'h01, 8'h33, 0, 0);   // 0x80, S
    do_op("R1",  1, 8'h41, 8'hFF, 8'h00, 8'h01, 0, 0);   // 0x00, Z C
    do_op("R1",  1, 8'h42, 8'h10, 8'h20, 8'h00, 0, 0);   // adc with C=1 -> 0x31
    do_op("R7",  1, 8'h43, 8'h10, 8'h20, 8'h05, 0, 0);   // imm operand
    do_op("R2",  1, 8'h44, 8'h05, 8'h06, 8'h00, 0, 0);   // 0xFF borrow
    do_op("R2",  1, 8'h46, 8'h10, 8'h0F, 8'h00, 0, 0);   // sbc with C=1 -> 0 Z
    do_op("R2",  1, 8'h45, 8'h00, 8'h00, 8'h01, 0, 0);   // set C for next
    do_op("R4",  1, 8'h70, 8'hF0, 8'h0F, 8'hFF, 0, 0);   // and -> 0, C kept
    do_op("R7",  1, 8'h71, 8'hF0, 8'h0F, 8'h30, 0, 0);
    do_op("R4",  1, 8'h73, 8'h80, 8'h00, 8'h01, 0, 0);
    do_op("R4",  1, 8'h74, 8'hAA, 8'hAA, 8'h00, 0, 0);
    do_op("R5",  1, 8'h50, 8'hFF, 8'h00, 8'h00, 0, 0);   // inc -> 0, C stays 1
    do_op("R5",  1, 8'h66, 8'h00, 8'h00, 8'h00, 0, 0);   // dec -> 0xFF
    do_op("R12", 1, 8'h00, 8'h12, 8'h00, 8'h00, 1, 1);   // set I only
    do_op("R6",  1, 8'h4F, 8'h5A, 8'h00, 8'h00, 0, 0);   // clear ZSC, I kept
    do_op("R3",  1, 8'h60, 8'h01, 8'h00, 8'h00, 0, 0);
    do_op("R8",  0, 8'h41, 8'hFF, 8'h00, 8'h01, 0, 0);   // disabled, flags hold
    do_op("R9",  1, 8'h48, 8'h77, 8'h01, 8'h01, 0, 0);   // illegal
    do_op("R9",  1, 8'h67, 8'h01, 8'h01, 8'h01, 0, 0);   // illegal
    do_op("R12", 1, 8'h41, 8'hFF, 8'h00, 8'h01, 1, 0);   // op plus clear I

    for (int k = 0; k < 300; k++) begin
      logic [7:0] opc;
      int sel;
      sel = $urandom_range(0, 5);
      case (sel)
        0: opc = 8'h40 + 8'($urandom_range(0, 7));
        1: opc = 8'h50 + 8'($urandom_range(0, 6));
        2: opc = 8'h60 + 8'($urandom_range(0, 6));
        3: opc = 8'h70 + 8'($urandom_range(0, 5));
        4: opc = 8'h4F;
        default: opc = 8'($urandom_range(0, 255));
      endcase
      do_op("R3", ($urandom_range(0, 7) != 0), opc, 8'($urandom), 8'($urandom),
            8'($urandom), ($urandom_range(0, 9) == 0), 1'($urandom));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule